// File: doc/BRIEF.md
# Triggered Readout Latency Buffer with Derandomizer

This block sits beside a real-time data path. One data word and its bunch-counter value arrive on every clock, and each clock is one bunch tick. The block writes every word into a circular history that reaches back further than the largest trigger latency. When a trigger accept arrives, the block looks back a programmable number of ticks to find the triggered tick. It then copies that tick and up to four ticks before it into a derandomizer FIFO, framed as one event.

An event is a header word, then the payload words, then a trailer word. The header carries the bunch counter of the triggered tick. The payload runs from the oldest tick to the triggered tick. The trailer carries the payload word count. A single readout lane empties the FIFO at one word per clock. The lane has no ready signal, so the block can never be held back by the lane.

When an accept comes and the FIFO cannot promise room for the whole event, the block drops the entire event. It never stalls. A sticky flag and a saturating counter record each drop. The same block can carry readout data or region-of-interest data: one instance is built per stream.

Top module: `trg_readout_buffer`

## Requirements
- R1: While reset is held and straight after it, out_valid, out_sop, out_eop and ovf_flag are 0, ovf_count is 0 and out_data equals IDLE_WORD.
- R2: The header of an event holds, in bits [BC_W-1:0], the in_bc value presented cfg_latency clocks before the clock that samples accept (cfg_latency 1..255). All higher bits are zero.
- R3: The payload has cfg_window words (1..5). These are the in_data words of the triggered tick and of the cfg_window-1 ticks before it, sent oldest first.
- R4: A header word has out_sop=1 and out_eop=0. A payload word has both flags at 0. A trailer word has out_eop=1, out_sop=0 and out_data equal to the payload count.
- R5: With the FIFO and the accept queue empty, the header appears on the output just after the second rising edge that follows the edge sampling accept. It is not there after the first.
- R6: Events leave in accept order. The words of one event appear on consecutive clocks, with no gap between header and trailer.
- R7: Whenever out_valid is 0, out_data equals IDLE_WORD and both framing flags are 0.
- R8: An accept is kept only if C + cfg_window + 2 <= FIFO_DEPTH. Here C counts the words already stored, plus the words still owed by earlier kept events. A word stops counting on the edge where it appears on the output. An accept that is not kept adds nothing to the output.
- R9: ovf_flag goes to 1 on the first dropped accept and stays 1 until reset.
- R10: ovf_count rises by one for each dropped accept and holds at its maximum value.
- R11: An event uses the cfg_latency and cfg_window values sampled together with its accept. Later changes do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Real-time data word of this tick |
| in_bc | input | BC_W | Bunch counter of this tick |
| accept | input | 1 | Trigger accept strobe, one clock per accept |
| cfg_latency | input | LAT_W | Look-back distance in ticks, 1..255 |
| cfg_window | input | WIN_W | Payload ticks per event, 1..MAX_WIN |
| out_valid | output | 1 | Readout word present; there is no ready signal |
| out_sop | output | 1 | Marks a header word |
| out_eop | output | 1 | Marks a trailer word |
| out_data | output | DATA_W | Readout word, or IDLE_WORD when not valid |
| ovf_flag | output | 1 | Sticky: at least one event was dropped |
| ovf_count | output | OVC_W | Saturating count of dropped events |

## Verification
The assertions assume that cfg_latency is never zero and that cfg_window stays within 1..MAX_WIN. They also assume the receiver takes every valid word, since there is no back-pressure. The bench keeps the configuration inside these ranges at all times, including the clock right after an accept, where it moves the values on purpose. The bench also runs a few hundred clocks before its first accept, so the look-back window only ever reads ticks that were actually written after reset.

// File: rtl/trg_pkg.sv
`timescale 1ns/1ps
package trg_pkg;
  // copy engine phases
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_PAY  = 2'd1,
    ENG_TRL  = 2'd2
  } eng_state_t;

  // tag stored with every derandomizer word
  typedef enum logic [1:0] {
    WK_PAY = 2'd0,
    WK_HDR = 2'd1,
    WK_TRL = 2'd2
  } word_kind_t;
endpackage

// File: rtl/trg_history.sv
`timescale 1ns/1ps
module trg_history #(
  parameter int DATA_W = 32,
  parameter int BC_W   = 12,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BC_W-1:0]   wr_bc,
  output logic [AW-1:0]     wr_ptr,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [BC_W-1:0]   rd_bc
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = DATA_W + BC_W;

  logic [EW-1:0] mem [DEPTH];

  // one entry per tick, overwritten after DEPTH ticks
  always_ff @(posedge clk) begin
    mem[wr_ptr] <= {wr_bc, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr + AW'(1);
  end

  assign {rd_bc, rd_data} = mem[rd_addr];
endmodule

// File: rtl/trg_admit.sv
`timescale 1ns/1ps
module trg_admit #(
  parameter int AW         = 9,
  parameter int LAT_W      = 8,
  parameter int WIN_W      = 3,
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 6,
  parameter int OVC_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic [AW-1:0]    wr_ptr,
  input  logic             out_pop,
  output logic             q_valid,
  output logic [AW-1:0]    q_trig,
  output logic [WIN_W-1:0] q_win,
  input  logic             q_pop,
  output logic [CNT_W-1:0] committed,
  output logic             ovf_flag,
  output logic [OVC_W-1:0] ovf_count
);
  // every queued event reserves at least three FIFO words
  localparam int QN   = FIFO_DEPTH / 3 + 1;
  localparam int Q_AW = (QN > 2) ? $clog2(QN) : 1;
  localparam int QD   = 1 << Q_AW;
  localparam int QEW  = AW + WIN_W;

  logic [QEW-1:0]   q_mem [QD];
  logic [Q_AW:0]    q_wp, q_rp;
  logic             q_full, room, keep, drop;
  logic [CNT_W-1:0] need;
  logic [AW-1:0]    trig;

  assign q_full = (q_wp[Q_AW] != q_rp[Q_AW]) &&
                  (q_wp[Q_AW-1:0] == q_rp[Q_AW-1:0]);
  assign q_valid = (q_wp != q_rp);
  assign {q_trig, q_win} = q_mem[q_rp[Q_AW-1:0]];

  assign need = CNT_W'(cfg_window) + CNT_W'(2);
  assign room = (committed + need) <= CNT_W'(FIFO_DEPTH);
  assign keep = accept && room && !q_full;
  assign drop = accept && !keep;
  assign trig = wr_ptr - AW'(cfg_latency);

  always_ff @(posedge clk) begin
    if (keep) q_mem[q_wp[Q_AW-1:0]] <= {trig, cfg_window};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wp      <= '0;
      q_rp      <= '0;
      committed <= '0;
      ovf_flag  <= 1'b0;
      ovf_count <= '0;
    end else begin
      if (keep)  q_wp <= q_wp + (Q_AW+1)'(1);
      if (q_pop) q_rp <= q_rp + (Q_AW+1)'(1);
      committed <= committed + (keep ? need : '0) - (out_pop ? CNT_W'(1) : '0);
      if (drop) begin
        ovf_flag <= 1'b1;
        if (ovf_count != {OVC_W{1'b1}}) ovf_count <= ovf_count + OVC_W'(1);
      end
    end
  end
endmodule

// File: rtl/trg_copy_engine.sv
`timescale 1ns/1ps
module trg_copy_engine import trg_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int BC_W   = 12,
  parameter int AW     = 9,
  parameter int WIN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  input  logic [AW-1:0]     q_trig,
  input  logic [WIN_W-1:0]  q_win,
  output logic              q_pop,
  output logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [BC_W-1:0]   rd_bc,
  output logic              wr_en,
  output word_kind_t        wr_kind,
  output logic [DATA_W-1:0] wr_data
);
  eng_state_t       state;
  logic [AW-1:0]    ptr;
  logic [WIN_W-1:0] cnt;

  always_comb begin
    rd_addr = ptr;
    wr_en   = 1'b0;
    wr_kind = WK_PAY;
    wr_data = rd_data;
    q_pop   = 1'b0;
    case (state)
      ENG_IDLE: begin
        rd_addr = q_trig;
        if (q_valid) begin
          wr_en   = 1'b1;
          wr_kind = WK_HDR;
          wr_data = DATA_W'(rd_bc);
        end
      end
      ENG_PAY: begin
        wr_en = 1'b1;
      end
      ENG_TRL: begin
        wr_en   = 1'b1;
        wr_kind = WK_TRL;
        wr_data = DATA_W'(q_win);
        q_pop   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      ptr   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (q_valid) begin
          state <= ENG_PAY;
          ptr   <= q_trig - AW'(q_win) + AW'(1);
          cnt   <= WIN_W'(1);
        end
        ENG_PAY: begin
          ptr <= ptr + AW'(1);
          if (cnt == q_win) state <= ENG_TRL;
          else              cnt   <= cnt + WIN_W'(1);
        end
        ENG_TRL: state <= ENG_IDLE;
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trg_derand_fifo.sv
`timescale 1ns/1ps
module trg_derand_fifo import trg_pkg::*; #(
  parameter int              DATA_W    = 32,
  parameter int              DEPTH     = 32,
  parameter int              FAW       = 5,
  parameter logic [DATA_W-1:0] IDLE_WORD = 32'hC0C0_C0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  word_kind_t        wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_pop,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data
);
  localparam int EW = DATA_W + 2;

  logic [EW-1:0]     mem [DEPTH];
  logic [FAW:0]      wp, rp;
  logic [1:0]        head_kind;
  logic [DATA_W-1:0] head_data;

  assign rd_pop = (wp != rp);
  assign {head_kind, head_data} = mem[rp[FAW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp[FAW-1:0]] <= {wr_kind, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= IDLE_WORD;
    end else begin
      if (wr_en) wp <= wp + (FAW+1)'(1);
      if (rd_pop) begin
        rp        <= rp + (FAW+1)'(1);
        out_valid <= 1'b1;
        out_sop   <= (head_kind == WK_HDR);
        out_eop   <= (head_kind == WK_TRL);
        out_data  <= head_data;
      end else begin
        out_valid <= 1'b0;
        out_sop   <= 1'b0;
        out_eop   <= 1'b0;
        out_data  <= IDLE_WORD;
      end
    end
  end
endmodule

// File: rtl/trg_readout_buffer.sv
`timescale 1ns/1ps
module trg_readout_buffer import trg_pkg::*; #(
  parameter int              DATA_W     = 32,
  parameter int              BC_W       = 12,
  parameter int              LAT_W      = 8,
  parameter int              WIN_W      = 3,
  parameter int              MAX_WIN    = 5,
  parameter int              HIST_AW    = 9,
  parameter int              FIFO_DEPTH = 32,
  parameter int              OVC_W      = 8,
  parameter logic [DATA_W-1:0] IDLE_WORD  = 32'hC0C0_C0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BC_W-1:0]   in_bc,
  input  logic              accept,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic [WIN_W-1:0]  cfg_window,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              ovf_flag,
  output logic [OVC_W-1:0]  ovf_count
);
  localparam int FAW   = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + MAX_WIN + 3);

  logic [HIST_AW-1:0] wr_ptr, rd_addr, q_trig;
  logic [DATA_W-1:0]  rd_data, eng_data;
  logic [BC_W-1:0]    rd_bc;
  logic [WIN_W-1:0]   q_win;
  logic               q_valid, q_pop, eng_wr, out_pop;
  word_kind_t         eng_kind;
  logic [CNT_W-1:0]   committed;

  trg_history #(.DATA_W(DATA_W), .BC_W(BC_W), .AW(HIST_AW)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_data(in_data), .wr_bc(in_bc),
    .wr_ptr(wr_ptr), .rd_addr(rd_addr), .rd_data(rd_data), .rd_bc(rd_bc)
  );

  trg_admit #(
    .AW(HIST_AW), .LAT_W(LAT_W), .WIN_W(WIN_W), .FIFO_DEPTH(FIFO_DEPTH),
    .CNT_W(CNT_W), .OVC_W(OVC_W)
  ) u_admit (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cfg_latency(cfg_latency),
    .cfg_window(cfg_window), .wr_ptr(wr_ptr), .out_pop(out_pop),
    .q_valid(q_valid), .q_trig(q_trig), .q_win(q_win), .q_pop(q_pop),
    .committed(committed), .ovf_flag(ovf_flag), .ovf_count(ovf_count)
  );

  trg_copy_engine #(.DATA_W(DATA_W), .BC_W(BC_W), .AW(HIST_AW), .WIN_W(WIN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_trig(q_trig), .q_win(q_win),
    .q_pop(q_pop), .rd_addr(rd_addr), .rd_data(rd_data), .rd_bc(rd_bc),
    .wr_en(eng_wr), .wr_kind(eng_kind), .wr_data(eng_data)
  );

  trg_derand_fifo #(
    .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .FAW(FAW), .IDLE_WORD(IDLE_WORD)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(eng_wr), .wr_kind(eng_kind), .wr_data(eng_data),
    .rd_pop(out_pop), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data)
  );
endmodule

// File: rtl/trg_readout_buffer_chk.sv
`timescale 1ns/1ps
module trg_readout_buffer_chk #(
  parameter int              DATA_W     = 32,
  parameter int              LAT_W      = 8,
  parameter int              WIN_W      = 3,
  parameter int              MAX_WIN    = 5,
  parameter int              FIFO_DEPTH = 32,
  parameter int              CNT_W      = 6,
  parameter int              OVC_W      = 8,
  parameter logic [DATA_W-1:0] IDLE_WORD  = 32'hC0C0_C0C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LAT_W-1:0]  cfg_latency,
  input logic [WIN_W-1:0]  cfg_window,
  input logic              out_valid,
  input logic              out_sop,
  input logic              out_eop,
  input logic [DATA_W-1:0] out_data,
  input logic              ovf_flag,
  input logic [OVC_W-1:0]  ovf_count,
  input logic [CNT_W-1:0]  committed
);
  p_latency_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_latency != '0);

  p_window_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_window != '0) && (int'(cfg_window) <= MAX_WIN));

  p_header_then_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |=> out_valid && !out_sop);

  p_flags_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sop && out_eop));

  p_gapless_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |=> out_valid);

  p_idle_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == IDLE_WORD) && !out_sop && !out_eop);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(committed) <= FIFO_DEPTH);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  p_count_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != '0) |-> ovf_flag);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> (ovf_count == $past(ovf_count) + OVC_W'(1)));
endmodule

bind trg_readout_buffer trg_readout_buffer_chk #(
  .DATA_W(DATA_W), .LAT_W(LAT_W), .WIN_W(WIN_W), .MAX_WIN(MAX_WIN),
  .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .OVC_W(OVC_W), .IDLE_WORD(IDLE_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_window(cfg_window),
  .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
  .ovf_flag(ovf_flag), .ovf_count(ovf_count), .committed(committed)
);

// File: tb/trg_readout_buffer_test.sv
`timescale 1ns/1ps
module trg_readout_buffer_test;
  localparam logic [31:0] IDLE = 32'hC0C0_C0C0;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = 32'h1234_5678;
  logic [11:0] in_bc = '0;
  logic        accept = 1'b0;
  logic [7:0]  cfg_latency = 8'd10;
  logic [2:0]  cfg_window = 3'd1;
  logic        out_valid, out_sop, out_eop, ovf_flag;
  logic [31:0] out_data;
  logic [7:0]  ovf_count;

  int errors = 0;
  int checks = 0;

  trg_readout_buffer uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_bc(in_bc), .accept(accept),
    .cfg_latency(cfg_latency), .cfg_window(cfg_window), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .ovf_flag(ovf_flag), .ovf_count(ovf_count)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // tick source: pseudo-random data, bunch counter wrapping at 3564
  always @(negedge clk) begin
    in_data = in_data * 32'h0019_660D + 32'h3C6E_F35F;
    in_bc   = (in_bc == 12'd3563) ? 12'd0 : in_bc + 12'd1;
  end

  // reference model of the requirements
  logic [31:0] h_data [1024];
  logic [11:0] h_bc   [1024];
  logic [31:0] sb_data [4096];
  logic [1:0]  sb_kind [4096];   // 1 header, 0 payload, 2 trailer
  int sb_head = 0, sb_tail = 0;
  int cyc = 0;
  int occ = 0;                   // words stored or owed (R8)
  int drops = 0;

  always @(posedge clk) begin : model
    int n, lat, base;
    if (rst_n) begin
      h_data[cyc % 1024] = in_data;
      h_bc[cyc % 1024]   = in_bc;
      if (accept) begin
        n = int'(cfg_window);
        lat = int'(cfg_latency);
        if (occ + n + 2 <= DEPTH) begin
          sb_data[sb_tail % 4096] = 32'(h_bc[(cyc - lat) % 1024]);
          sb_kind[sb_tail % 4096] = 2'd1;
          sb_tail++;
          base = cyc - lat - (n - 1);
          for (int k = 0; k < n; k++) begin
            sb_data[sb_tail % 4096] = h_data[(base + k) % 1024];
            sb_kind[sb_tail % 4096] = 2'd0;
            sb_tail++;
          end
          sb_data[sb_tail % 4096] = 32'(n);
          sb_kind[sb_tail % 4096] = 2'd2;
          sb_tail++;
          occ += n + 2;
        end else begin
          drops++;
        end
      end
      cyc++;
    end
  end

  always @(negedge clk) begin : monitor
    logic [1:0] k;
    if (rst_n) begin
      if (out_valid) begin
        occ--;
        if (sb_head == sb_tail) begin
          chk(1'b0, "R6 unexpected word", 64'(out_data), 64'(IDLE));
        end else begin
          k = sb_kind[sb_head % 4096];
          chk(out_sop == (k == 2'd1) && out_eop == (k == 2'd2), "R4 framing flags",
              64'({out_sop, out_eop}), 64'({k == 2'd1, k == 2'd2}));
          if (k == 2'd1)
            chk(out_data == sb_data[sb_head % 4096], "R2 header bunch counter",
                64'(out_data), 64'(sb_data[sb_head % 4096]));
          else if (k == 2'd0)
            chk(out_data == sb_data[sb_head % 4096], "R3 payload word",
                64'(out_data), 64'(sb_data[sb_head % 4096]));
          else
            chk(out_data == sb_data[sb_head % 4096], "R4 trailer count R11",
                64'(out_data), 64'(sb_data[sb_head % 4096]));
          sb_head++;
        end
      end else begin
        chk(out_data == IDLE && !out_sop && !out_eop, "R7 idle word",
            64'(out_data), 64'(IDLE));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic burst(input int len, input int lat, input int win);
    @(negedge clk);
    cfg_latency = 8'(lat);
    cfg_window  = 3'(win);
    accept = 1'b1;
    repeat (len) @(negedge clk);
    accept = 1'b0;
    repeat (400) @(negedge clk);
  endtask

  initial begin : stim
    int lat_list[8] = '{1, 2, 3, 4, 9, 64, 200, 255};
    int exp_cnt;
    repeat (4) @(negedge clk);
    // R1 while in reset
    chk(!out_valid && !out_sop && !out_eop, "R1 framing idle in reset",
        64'({out_valid, out_sop, out_eop}), 64'(0));
    chk(out_data == IDLE, "R1 idle word in reset", 64'(out_data), 64'(IDLE));
    chk(!ovf_flag && ovf_count == 8'd0, "R1 overflow state in reset",
        64'({ovf_flag, ovf_count}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && out_data == IDLE && !ovf_flag && ovf_count == 8'd0,
        "R1 state after reset release", 64'(out_data), 64'(IDLE));
    repeat (300) @(negedge clk);

    // sweep of latency x window, one isolated accept each (R2 R3 R5 R11)
    foreach (lat_list[i]) begin
      for (int n = 1; n <= 5; n++) begin
        cfg_latency = 8'(lat_list[i]);
        cfg_window  = 3'(n);
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        // move the configuration right after the accept (R11)
        cfg_window  = 3'((n % 5) + 1);
        cfg_latency = (lat_list[i] == 255) ? 8'd1 : 8'(lat_list[i] + 1);
        @(negedge clk);
        chk(!out_valid, "R5 header not after first edge", 64'(out_valid), 64'(0));
        @(negedge clk);
        chk(out_valid && out_sop, "R5 header after second edge",
            64'({out_valid, out_sop}), 64'(3));
        repeat (10) @(negedge clk);
      end
    end
    chk(!ovf_flag, "R9 no flag without drops", 64'(ovf_flag), 64'(0));

    // back-to-back accepts with wide window overrun the FIFO (R8 R9 R10)
    burst(24, 20, 5);
    chk(drops > 0, "R8 burst causes drops", 64'(drops), 64'(1));
    chk(ovf_flag == 1'b1, "R9 flag set after drop", 64'(ovf_flag), 64'(1));
    chk(int'(ovf_count) == drops, "R10 count equals drops", 64'(ovf_count), 64'(drops));
    chk(sb_head == sb_tail, "R6 all kept events delivered", 64'(sb_head), 64'(sb_tail));

    // narrow window burst, different fill pattern
    burst(40, 7, 1);
    chk(int'(ovf_count) == drops, "R10 count after narrow burst",
        64'(ovf_count), 64'(drops));
    chk(sb_head == sb_tail, "R6 narrow burst delivered", 64'(sb_head), 64'(sb_tail));

    // isolated accept afterwards: flag stays, count unchanged (R9)
    exp_cnt = drops;
    burst(1, 33, 3);
    chk(ovf_flag == 1'b1, "R9 flag sticky", 64'(ovf_flag), 64'(1));
    chk(int'(ovf_count) == exp_cnt, "R10 no count without drop",
        64'(ovf_count), 64'(exp_cnt));

    // long burst drives the counter into saturation (R10)
    burst(420, 100, 5);
    exp_cnt = (drops > 255) ? 255 : drops;
    chk(int'(ovf_count) == exp_cnt, "R10 count saturates",
        64'(ovf_count), 64'(exp_cnt));
    chk(drops > 255, "R10 enough drops to saturate", 64'(drops), 64'(256));
    chk(sb_head == sb_tail, "R6 long burst delivered", 64'(sb_head), 64'(sb_tail));
    finish_run();
  end
endmodule